// File: doc/BRIEF.md
# Dual-Format Parallel Video Port

This block is the pixel-path edge of a video codec. It has one parallel video lane and three sync signals (line, frame and field). In encode direction it captures samples from the lane and passes each one to the core with a component tag. In decode direction it requests samples from the core and drives them onto the lane. Line and field timing never come from codes embedded in the data. They come from the sync signals, so every sample code, including 0, 255 and all-ones, is treated as picture data.

Two lane formats are supported. In the multiplexed format, 4:2:2 samples are interleaved on the lane in the order Cb, Y, Cr, Y. In the grayscale format, luma-only samples of up to 12 bits are carried, and the clock runs at twice the sample rate. The core selects three modes. The sync source is either generated inside the port (master) or taken from external inputs (slave). The direction is encode or decode. The generated field length is 525-line or 625-line.

In master mode, the line length, active pixels per line and active lines per field are programmable. The total number of lines per field follows from the line-standard selection.

Top module: `vid_port`

## Requirements
- R1: In multiplexed mode, active samples carry the tags Cb=0, Y=1, Cr=2 in the repeating order Cb, Y, Cr, Y. The order restarts at Cb on the first active sample after any blanking cycle.
- R2: Every code on the lane, including 0, 255 and 4095, is forwarded unchanged in capture and in emission. No code has any effect on timing.
- R3: On a clock where the effective line sync or frame sync is high, no sample is captured (cap_valid_o low), no sample is requested (emit_ready_o low) and vd_o is driven to 0 after that edge.
- R4: In encode direction, a sample taken in an active slot appears on cap_data_o and cap_comp_o after that edge, with cap_valid_o high for exactly one cycle.
- R5: In grayscale mode, only every second active clock is a sample slot, and the tag is always Y=1.
- R6: In grayscale mode, the slot phase restarts on every blanking cycle. The first active clock after blanking is skipped and the second is sampled.
- R7: In master mode, a line lasts h_total clocks counted from 0. hsync_o is high for counts h_active to h_total-1.
- R8: In master mode, a field lasts 262 lines (cfg_625_i=0) or 312 lines (cfg_625_i=1). vsync_o is high for lines v_active to the last line.
- R9: field_o is 0 after reset and inverts once at the end of each generated field.
- R10: sync_oe_o equals cfg_master_i. In master mode, hsync_i, vsync_i and field_i have no effect. In slave mode, hsync_o, vsync_o and field_o stay 0.
- R11: In decode direction, emit_ready_o is high in each active slot and emit_comp_o gives the tag wanted. vd_o carries emit_data_i after that edge if emit_valid_i was high, and 0 otherwise. vd_oe_o equals cfg_decode_i.
- R12: In decode direction, cap_valid_o stays 0. In encode direction, emit_ready_o stays 0 and vd_o stays 0.
- R13: After reset, cap_valid_o, cap_data_o, cap_comp_o, vd_o and field_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video clock; lane sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_master_i | input | 1 | 1: port generates sync; 0: sync taken from inputs |
| cfg_decode_i | input | 1 | 1: lane driven from core; 0: lane captured to core |
| cfg_gray_i | input | 1 | 1: grayscale half-rate format; 0: multiplexed 4:2:2 |
| cfg_625_i | input | 1 | Field length for generated sync: 0 = 262 lines, 1 = 312 lines |
| cfg_h_total_i | input | 12 | Clocks per generated line |
| cfg_h_active_i | input | 12 | Active clocks per generated line |
| cfg_v_active_i | input | 10 | Active lines per generated field |
| hsync_i | input | 1 | External line sync (slave) |
| vsync_i | input | 1 | External frame sync (slave) |
| field_i | input | 1 | External field flag (slave, informational) |
| hsync_o | output | 1 | Generated line sync |
| vsync_o | output | 1 | Generated frame sync |
| field_o | output | 1 | Generated field flag |
| sync_oe_o | output | 1 | Drive enable for the sync pins |
| vd_i | input | 12 | Lane input |
| vd_o | output | 12 | Lane output |
| vd_oe_o | output | 1 | Drive enable for the lane |
| cap_valid_o | output | 1 | Captured sample valid (one cycle) |
| cap_data_o | output | 12 | Captured sample |
| cap_comp_o | output | 2 | Captured sample tag |
| emit_ready_o | output | 1 | Port takes a sample this cycle |
| emit_comp_o | output | 2 | Tag of the sample requested |
| emit_valid_i | input | 1 | Core offers a sample |
| emit_data_i | input | 12 | Sample from the core |

## Verification
The sensitive collision is a sync edge landing in the same cycle as an advance of the component or phase counter. When blanking arrives on a cycle that would otherwise be a slot, the counter must restart instead of stepping, and the next active sample must be Cb (or, in grayscale, the skipped first edge). Random per-cycle line and frame sync, in slave mode and also against the generated sync in master mode, produces this many times per run. A bench model derived from R1, R3, R5 and R6 predicts every tag, every valid and every lane value for each cycle, and the outputs are compared against it.

// File: rtl/vid_pkg.sv
package vid_pkg;
  typedef enum logic [1:0] {
    COMP_CB = 2'd0,
    COMP_Y  = 2'd1,
    COMP_CR = 2'd2
  } comp_e;

  localparam int LINES_525 = 262;
  localparam int LINES_625 = 312;
endpackage

// File: rtl/vid_timing.sv
module vid_timing #(
  parameter int HCW  = 12,
  parameter int VCW  = 10,
  parameter int L525 = vid_pkg::LINES_525,
  parameter int L625 = vid_pkg::LINES_625
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           cfg_625_i,
  input  logic [HCW-1:0] h_total_i,
  input  logic [HCW-1:0] h_active_i,
  input  logic [VCW-1:0] v_active_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           field_o
);
  localparam logic [VCW-1:0] VLAST_525 = VCW'(L525 - 1);
  localparam logic [VCW-1:0] VLAST_625 = VCW'(L625 - 1);

  logic [HCW-1:0] h_cnt;
  logic [VCW-1:0] v_cnt, v_last;
  logic           fld, h_end, v_end;

  assign v_last = cfg_625_i ? VLAST_625 : VLAST_525;
  assign h_end  = h_cnt >= (h_total_i - HCW'(1));
  assign v_end  = v_cnt >= v_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt <= '0;
      v_cnt <= '0;
      fld   <= 1'b0;
    end else if (!en_i) begin
      h_cnt <= '0;
      v_cnt <= '0;
      fld   <= 1'b0;
    end else if (h_end) begin
      h_cnt <= '0;
      if (v_end) begin
        v_cnt <= '0;
        fld   <= ~fld;
      end else begin
        v_cnt <= v_cnt + VCW'(1);
      end
    end else begin
      h_cnt <= h_cnt + HCW'(1);
    end
  end

  assign hsync_o = en_i & (h_cnt >= h_active_i);
  assign vsync_o = en_i & (v_cnt >= v_active_i);
  assign field_o = fld;

  // R9
  field_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && (field_o != $past(field_o))) |-> $past(h_end && v_end));

  // R7
  line_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && en_i && $past(h_end)) |-> (h_cnt == '0));
endmodule

// File: rtl/vid_slot.sv
module vid_slot
  import vid_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gray_i,
  input  logic       blank_i,
  output logic       slot_o,
  output logic [1:0] comp_o
);
  logic       phase;
  logic [1:0] cnt;

  // grayscale takes the second edge of each pair
  assign slot_o = !blank_i && (!gray_i || phase);

  always_comb begin
    if (gray_i)           comp_o = COMP_Y;
    else if (cnt == 2'd0) comp_o = COMP_CB;
    else if (cnt == 2'd2) comp_o = COMP_CR;
    else                  comp_o = COMP_Y;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= 1'b0;
      cnt   <= '0;
    end else if (blank_i) begin
      phase <= 1'b0;
      cnt   <= '0;
    end else begin
      phase <= ~phase;
      if (slot_o) cnt <= cnt + 2'd1;
    end
  end

  // R1
  cb_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(blank_i) && !gray_i) |-> (comp_o == COMP_CB));

  // R6
  gray_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(blank_i) && gray_i) |-> !slot_o);
endmodule

// File: rtl/vid_lane.sv
module vid_lane #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          decode_i,
  input  logic          slot_i,
  input  logic [1:0]    comp_i,
  input  logic [DW-1:0] vd_i,
  input  logic          emit_valid_i,
  input  logic [DW-1:0] emit_data_i,
  output logic          cap_valid_o,
  output logic [DW-1:0] cap_data_o,
  output logic [1:0]    cap_comp_o,
  output logic [DW-1:0] vd_o
);
  logic take, give;

  assign take = !decode_i && slot_i;
  assign give = decode_i && slot_i && emit_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_valid_o <= 1'b0;
      cap_data_o  <= '0;
      cap_comp_o  <= '0;
      vd_o        <= '0;
    end else begin
      cap_valid_o <= take;
      if (take) begin
        cap_data_o <= vd_i;
        cap_comp_o <= comp_i;
      end
      vd_o <= give ? emit_data_i : '0;
    end
  end

  // R11
  lane_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vd_o != '0) |-> $past(decode_i && slot_i && emit_valid_i));

  // R12
  cap_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o |-> $past(!decode_i));
endmodule

// File: rtl/vid_port.sv
module vid_port #(
  parameter int DW  = 12,
  parameter int HCW = 12,
  parameter int VCW = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_master_i,
  input  logic           cfg_decode_i,
  input  logic           cfg_gray_i,
  input  logic           cfg_625_i,
  input  logic [HCW-1:0] cfg_h_total_i,
  input  logic [HCW-1:0] cfg_h_active_i,
  input  logic [VCW-1:0] cfg_v_active_i,
  input  logic           hsync_i,
  input  logic           vsync_i,
  input  logic           field_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           field_o,
  output logic           sync_oe_o,
  input  logic [DW-1:0]  vd_i,
  output logic [DW-1:0]  vd_o,
  output logic           vd_oe_o,
  output logic           cap_valid_o,
  output logic [DW-1:0]  cap_data_o,
  output logic [1:0]     cap_comp_o,
  output logic           emit_ready_o,
  output logic [1:0]     emit_comp_o,
  input  logic           emit_valid_i,
  input  logic [DW-1:0]  emit_data_i
);
  logic       gen_hs, gen_vs, gen_fld;
  logic       hs_eff, vs_eff, blank, slot;
  logic [1:0] comp;
  logic       unused_fld;

  vid_timing #(.HCW(HCW), .VCW(VCW)) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg_master_i),
    .cfg_625_i  (cfg_625_i),
    .h_total_i  (cfg_h_total_i),
    .h_active_i (cfg_h_active_i),
    .v_active_i (cfg_v_active_i),
    .hsync_o    (gen_hs),
    .vsync_o    (gen_vs),
    .field_o    (gen_fld)
  );

  // field flag is informational only on the capture path
  assign unused_fld = field_i;

  assign hs_eff = cfg_master_i ? gen_hs : hsync_i;
  assign vs_eff = cfg_master_i ? gen_vs : vsync_i;
  assign blank  = hs_eff | vs_eff;

  vid_slot u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gray_i  (cfg_gray_i),
    .blank_i (blank),
    .slot_o  (slot),
    .comp_o  (comp)
  );

  vid_lane #(.DW(DW)) u_lane (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .decode_i     (cfg_decode_i),
    .slot_i       (slot),
    .comp_i       (comp),
    .vd_i         (vd_i),
    .emit_valid_i (emit_valid_i),
    .emit_data_i  (emit_data_i),
    .cap_valid_o  (cap_valid_o),
    .cap_data_o   (cap_data_o),
    .cap_comp_o   (cap_comp_o),
    .vd_o         (vd_o)
  );

  assign hsync_o      = gen_hs;
  assign vsync_o      = gen_vs;
  assign field_o      = gen_fld;
  assign sync_oe_o    = cfg_master_i;
  assign vd_oe_o      = cfg_decode_i;
  assign emit_ready_o = cfg_decode_i & slot;
  assign emit_comp_o  = comp;

  // R3
  blank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o |-> $past(!blank));

  // R5
  gray_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_valid_o && $past(cfg_gray_i) && $past(cfg_gray_i, 2)) |-> !$past(cap_valid_o));

  // R10
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_master_i |-> !(hsync_o || vsync_o));
endmodule

// File: tb/sim_vid_port.sv
module sim_vid_port;
  localparam int DW = 12;
  localparam int HT = 8;
  localparam int HA = 5;
  localparam int VA = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 0, decode = 0, gray = 0, c625 = 0;
  logic hs_in = 0, vs_in = 0, fld_in = 0;
  logic [DW-1:0] vd = '0, ed = '0;
  logic ev = 0;

  logic hs_o, vs_o, fld_o, sync_oe, vd_oe, cap_v, emit_rdy;
  logic [DW-1:0] vd_out, cap_d;
  logic [1:0] cap_c, emit_c;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // model state
  int mh, mv;
  bit mf, ph;
  int cnt;
  bit e_cv;
  logic [DW-1:0] e_cd, e_vd;
  int e_cc;

  always #4 clk = ~clk;

  vid_port u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_master_i(master), .cfg_decode_i(decode), .cfg_gray_i(gray), .cfg_625_i(c625),
    .cfg_h_total_i(12'(HT)), .cfg_h_active_i(12'(HA)), .cfg_v_active_i(10'(VA)),
    .hsync_i(hs_in), .vsync_i(vs_in), .field_i(fld_in),
    .hsync_o(hs_o), .vsync_o(vs_o), .field_o(fld_o), .sync_oe_o(sync_oe),
    .vd_i(vd), .vd_o(vd_out), .vd_oe_o(vd_oe),
    .cap_valid_o(cap_v), .cap_data_o(cap_d), .cap_comp_o(cap_c),
    .emit_ready_o(emit_rdy), .emit_comp_o(emit_c),
    .emit_valid_i(ev), .emit_data_i(ed)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int tag_of(input bit g, input int c);
    if (g) return 1;
    if (c == 0) return 0;
    if (c == 2) return 2;
    return 1;
  endfunction

  function automatic logic [DW-1:0] pick_code();
    case ($urandom % 5)
      0: return '0;
      1: return 12'd255;
      2: return 12'hFFF;
      default: return DW'($urandom);
    endcase
  endfunction

  task automatic do_reset(input bit m, input bit d, input bit g, input bit f625);
    @(negedge clk);
    rst_n = 1'b0;
    master = m; decode = d; gray = g; c625 = f625;
    hs_in = 0; vs_in = 0; ev = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    chk(cap_v == 0, "R13 cap_valid", 32'(cap_v), 0);
    chk(cap_d == 0, "R13 cap_data", 32'(cap_d), 0);
    chk(cap_c == 0, "R13 cap_comp", 32'(cap_c), 0);
    chk(vd_out == 0, "R13 vd_o", 32'(vd_out), 0);
    chk(fld_o == 0, "R13/R9 field_o", 32'(fld_o), 0);
    mh = 0; mv = 0; mf = 0; ph = 0; cnt = 0;
    e_cv = 0; e_cd = '0; e_vd = '0; e_cc = 0;
  endtask

  // call at a negedge; checks last edge's result, then drives and predicts the next
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      bit m_hs, m_vs, blank, slot;
      int comp, vlast;
      if (i > 0) @(negedge clk);
      chk(cap_v == e_cv, decode ? "R12 cap_valid" : "R4/R3/R5 cap_valid", 32'(cap_v), 32'(e_cv));
      if (e_cv) begin
        chk(cap_d == e_cd, "R2/R4 cap_data", 32'(cap_d), 32'(e_cd));
        chk(32'(cap_c) == 32'(e_cc), "R1/R5 cap_comp", 32'(cap_c), 32'(e_cc));
      end
      chk(vd_out == e_vd, "R11/R2/R3 vd_o", 32'(vd_out), 32'(e_vd));
      hs_in = ($urandom % 6) == 0;
      vs_in = ($urandom % 40) == 0;
      fld_in = $urandom % 2;
      vd = pick_code();
      ed = pick_code();
      ev = ($urandom % 4) != 0;
      #1;
      vlast = c625 ? 311 : 261;
      m_hs = master ? (mh >= HA) : hs_in;
      m_vs = master ? (mv >= VA) : vs_in;
      blank = m_hs | m_vs;
      slot = !blank && (!gray || ph);
      comp = tag_of(gray, cnt);
      chk(sync_oe == master, "R10 sync_oe", 32'(sync_oe), 32'(master));
      chk(vd_oe == decode, "R11 vd_oe", 32'(vd_oe), 32'(decode));
      if (master) begin
        chk(hs_o == (mh >= HA), "R7 hsync_o", 32'(hs_o), 32'(mh >= HA));
        chk(vs_o == (mv >= VA), "R8 vsync_o", 32'(vs_o), 32'(mv >= VA));
        chk(fld_o == mf, "R9 field_o", 32'(fld_o), 32'(mf));
      end else begin
        chk({hs_o, vs_o, fld_o} == 3'b000, "R10 slave sync outs", 32'({hs_o, vs_o, fld_o}), 0);
      end
      chk(emit_rdy == (decode && slot), "R11/R12 emit_ready", 32'(emit_rdy), 32'(decode && slot));
      if (decode && slot)
        chk(32'(emit_c) == 32'(comp), "R1/R5 emit_comp", 32'(emit_c), 32'(comp));
      e_cv = !decode && slot;
      e_cd = vd;
      e_cc = comp;
      e_vd = (decode && slot && ev) ? ed : '0;
      if (blank) begin ph = 0; cnt = 0; end
      else begin
        ph = !ph;
        if (slot) cnt = (cnt + 1) % 4;
      end
      if (master) begin
        if (mh >= HT - 1) begin
          mh = 0;
          if (mv >= vlast) begin mv = 0; mf = !mf; end
          else mv++;
        end else mh++;
      end
    end
  endtask

  // directed R6: active after blanking, first edge skipped in gray
  task automatic gray_line_start();
    @(negedge clk);
    hs_in = 1; vs_in = 0; vd = 12'h0AA;
    @(negedge clk);
    hs_in = 0; vd = 12'h111;
    @(negedge clk);
    chk(cap_v == 0, "R6 first edge skipped", 32'(cap_v), 0);
    vd = 12'h222;
    @(negedge clk);
    chk(cap_v == 1, "R6 second edge taken", 32'(cap_v), 1);
    chk(cap_d == 12'h222, "R6 sample value", 32'(cap_d), 32'h222);
    chk(cap_c == 2'd1, "R5 gray tag", 32'(cap_c), 1);
    @(negedge clk);
    chk(cap_v == 0, "R5 half rate", 32'(cap_v), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(0, 0, 0, 0); run(3000);
    do_reset(0, 1, 0, 0); run(2000);
    do_reset(0, 0, 1, 0); run(2000);
    do_reset(0, 0, 1, 0); gray_line_start();
    do_reset(0, 1, 1, 0); run(1500);
    do_reset(1, 0, 0, 0); run(4500);
    do_reset(1, 1, 1, 1); run(5200);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule